// File: doc/BRIEF.md
# Exception Entry Unit

This block performs the architectural side of taking an exception in a 64-bit core. Several pipeline requesters can raise a one-cycle exception request, each with a cause and a faulting address. The core also supplies the faulting PC, a flag that marks a branch-delay-slot instruction, and a base offset. On the clock edge that accepts a request, the block updates its control-register fields together: the exception code, the exception PC, the branch-delay flag, the exception-level bit, the bad-address register and the translation-context fields. On that same edge it produces a registered redirect target for the fetch stage.

The block also works out the current privilege level from the exception level, the error level and the mode field, and drives it to the rest of the core. It checks accesses to the control registers. An access made from a non-kernel level while control-register usability is disabled raises a coprocessor-unusable exception. A separate input clears the exception level on exception return.

Top module: `exc_entry_unit`

## Requirements
- R1: Every accepted exception sets the exception-level output `exl` to 1 on the same edge. If `exl_clr` is asserted in the same cycle, the exception wins. `exl_clr` on its own clears `exl`.
- R2: `epc` and `bd` are written only when `exl` was 0 before the request. A nested exception, taken while `exl` is 1, leaves both unchanged.
- R3: For a first-level exception with `in_delay`=1, `epc` gets `pc`-4 and `bd` gets 1. With `in_delay`=0, `epc` gets `pc` and `bd` gets 0.
- R4: The redirect target is base + offset - `base_off`. The base is 0xFFFFFFFFBFC00200 when `bev`=1 and 0xFFFFFFFF80000000 when `bev`=0. The offset is 0x180 when `exl` was already 1. Otherwise it is 0x080 for the TLB-refill causes (14, 15), 0x280 for the coprocessor-2 trap cause (13), and 0x180 for all other causes.
- R5: Each cause maps to a 5-bit `exc_code`. The cause encoding on `req_cause` is followed by the code in brackets:
  - interrupt 0 [0]
  - TLB modify 1 [1]
  - TLB load 2 [2]
  - TLB store 3 [3]
  - address-error load 4 [4]
  - address-error store 5 [5]
  - syscall 6 [8]
  - breakpoint 7 [9]
  - reserved instruction 8 [0x0A]
  - coprocessor unusable 9 [0x0B]
  - overflow 10 [0x0C]
  - trap 11 [0x0D]
  - coprocessor-2 exception 12 [0x12]
  - coprocessor-2 trap 13 [0x12]
  - refill load 14 [2]
  - refill store 15 [3]
  - invalid load 16 [2]
  - invalid store 17 [3]
  - machine check 18 [0x18]
- R6: On a TLB-class cause (1, 2, 3, 14 to 17), the faulting address A is captured as follows. `ctx_badvpn2` gets A[31:13]. `xctx_badvpn2` and `hi_vpn2` get A[39:13]. `xctx_r` and `hi_region` get A[63:62]. Other causes leave all of these unchanged.
- R7: `badvaddr` gets the faulting address on TLB-class causes and on address-error causes (4, 5). Every other cause leaves it unchanged.
- R8: `priv` is 0 (kernel) when `exl` or `erl` is 1. Otherwise `ksu`=00 gives 0, `ksu`=01 gives 1 (supervisor), and `ksu`=10 or 11 gives 2 (user). The output is registered and follows its inputs one edge later.
- R9: A `cp0_access` pulse while the level is not kernel and `cu0`=0 raises exception code 0x0B. The pulse has no effect at kernel level or when `cu0`=1.
- R10: When several requesters fire in one cycle, the lowest-numbered one supplies the cause and the address. The control-register access check has the lowest priority of all.
- R11: `redirect_valid` is a one-cycle pulse on the same edge as the register updates. `redirect_pc` holds the target of the most recent exception.
- R12: After reset, `exl`, `bd`, `redirect_valid`, `epc`, `badvaddr`, `exc_code` and `priv` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | One-cycle exception request per requester |
| req_cause | input | 5*NREQ | Cause per requester, 5 bits each, requester 0 in the low bits |
| req_addr | input | 64*NREQ | Faulting address per requester |
| pc | input | 64 | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| base_off | input | 64 | Value subtracted from the vector address |
| bev | input | 1 | Boot-vector select |
| erl | input | 1 | Error level |
| ksu | input | 2 | Mode field |
| cu0 | input | 1 | Control-register usability enable |
| cp0_access | input | 1 | Control-register access this cycle |
| exl_clr | input | 1 | Clear exception level (exception return) |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | 64 | Next-PC target |
| exl | output | 1 | Exception level |
| epc | output | 64 | Exception PC |
| bd | output | 1 | Branch-delay flag of the exception |
| exc_code | output | 5 | Exception code |
| badvaddr | output | 64 | Bad virtual address |
| ctx_badvpn2 | output | 19 | Context page number field |
| xctx_badvpn2 | output | 27 | Extended-context page number field |
| xctx_r | output | 2 | Extended-context region field |
| hi_vpn2 | output | 27 | Entry-high page number field |
| hi_region | output | 2 | Entry-high region field |
| priv | output | 2 | Privilege level: 0 kernel, 1 supervisor, 2 user |

## Verification
The assertions assume that every cause on `req_cause` is an encoding from 0 to 18. Codes above 18 are decoded as reserved instruction, and no property covers them. The assertions also assume that requests are single-cycle pulses. The stimulus uses only defined cause encodings and raises each request for exactly one cycle. It clears `exl` explicitly before any vector that expects a first-level entry, and it raises a preliminary interrupt before any vector that expects a nested entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;
  localparam int CODE_W  = 5;

  typedef enum logic [CAUSE_W-1:0] {
    EX_IRQ       = 5'd0,
    EX_TLB_MOD   = 5'd1,
    EX_TLB_LD    = 5'd2,
    EX_TLB_ST    = 5'd3,
    EX_ADR_LD    = 5'd4,
    EX_ADR_ST    = 5'd5,
    EX_SYSCALL   = 5'd6,
    EX_BREAK     = 5'd7,
    EX_RSVD      = 5'd8,
    EX_COP_UNUSE = 5'd9,
    EX_OVF       = 5'd10,
    EX_TRAP      = 5'd11,
    EX_CP2_EXC   = 5'd12,
    EX_CP2_TRAP  = 5'd13,
    EX_REFILL_LD = 5'd14,
    EX_REFILL_ST = 5'd15,
    EX_INV_LD    = 5'd16,
    EX_INV_ST    = 5'd17,
    EX_MCHECK    = 5'd18
  } exc_cause_e;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2
  } priv_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              tlb_class;
    logic              addr_err;
    logic              refill;
    logic              cp2_trap;
  } cause_info_t;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_pkg::*;
(
  input  exc_cause_e  cause,
  output cause_info_t info
);
  always_comb begin
    info = '{code: 5'h0A, tlb_class: 1'b0, addr_err: 1'b0, refill: 1'b0, cp2_trap: 1'b0};
    unique case (cause)
      EX_IRQ:       info.code = 5'h00;
      EX_TLB_MOD:   begin info.code = 5'h01; info.tlb_class = 1'b1; end
      EX_TLB_LD:    begin info.code = 5'h02; info.tlb_class = 1'b1; end
      EX_TLB_ST:    begin info.code = 5'h03; info.tlb_class = 1'b1; end
      EX_ADR_LD:    begin info.code = 5'h04; info.addr_err = 1'b1; end
      EX_ADR_ST:    begin info.code = 5'h05; info.addr_err = 1'b1; end
      EX_SYSCALL:   info.code = 5'h08;
      EX_BREAK:     info.code = 5'h09;
      EX_RSVD:      info.code = 5'h0A;
      EX_COP_UNUSE: info.code = 5'h0B;
      EX_OVF:       info.code = 5'h0C;
      EX_TRAP:      info.code = 5'h0D;
      EX_CP2_EXC:   info.code = 5'h12;
      EX_CP2_TRAP:  begin info.code = 5'h12; info.cp2_trap = 1'b1; end
      EX_REFILL_LD: begin info.code = 5'h02; info.tlb_class = 1'b1; info.refill = 1'b1; end
      EX_REFILL_ST: begin info.code = 5'h03; info.tlb_class = 1'b1; info.refill = 1'b1; end
      EX_INV_LD:    begin info.code = 5'h02; info.tlb_class = 1'b1; end
      EX_INV_ST:    begin info.code = 5'h03; info.tlb_class = 1'b1; end
      EX_MCHECK:    info.code = 5'h18;
      default:      info.code = 5'h0A;
    endcase
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] valid,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i]) grant = N'(1) << i;
    end
  end

  assign any = |valid;

  // R10: at most one winner, and a request always yields one
  a_r10_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any == (grant != '0)));
  a_r10_low_wins: assert property (@(posedge clk) disable iff (rst)
    valid[0] |-> grant[0]);
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000
) (
  input  logic            bev,
  input  logic            exl_now,
  input  logic            refill,
  input  logic            cp2_trap,
  input  logic [XLEN-1:0] base_off,
  output logic [XLEN-1:0] target
);
  localparam logic [11:0] OFF_REFILL = 12'h080;
  localparam logic [11:0] OFF_COMMON = 12'h180;
  localparam logic [11:0] OFF_CP2    = 12'h280;

  logic [11:0]     off;
  logic [XLEN-1:0] base;

  always_comb begin
    if (exl_now)       off = OFF_COMMON;
    else if (refill)   off = OFF_REFILL;
    else if (cp2_trap) off = OFF_CP2;
    else               off = OFF_COMMON;
  end

  assign base   = bev ? BOOT_BASE[XLEN-1:0] : NORM_BASE[XLEN-1:0];
  assign target = base + {{(XLEN-12){off[11]}}, off} - base_off;
endmodule

// File: rtl/exc_priv_decode.sv
module exc_priv_decode
  import exc_pkg::*;
(
  input  logic       exl_in,
  input  logic       erl_in,
  input  logic [1:0] ksu_in,
  output priv_e      level
);
  always_comb begin
    if (exl_in || erl_in) level = PRIV_KERNEL;
    else begin
      unique case (ksu_in)
        2'b00:   level = PRIV_KERNEL;
        2'b01:   level = PRIV_SUPER;
        default: level = PRIV_USER;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NREQ    = 3,
  parameter int VPN_LO  = 13,
  parameter int CTX_HI  = 31,
  parameter int XCTX_HI = 39
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREQ-1:0]         req_valid,
  input  logic [NREQ*CAUSE_W-1:0] req_cause,
  input  logic [NREQ*XLEN-1:0]    req_addr,
  input  logic [XLEN-1:0]         pc,
  input  logic                    in_delay,
  input  logic [XLEN-1:0]         base_off,
  input  logic                    bev,
  input  logic                    erl,
  input  logic [1:0]              ksu,
  input  logic                    cu0,
  input  logic                    cp0_access,
  input  logic                    exl_clr,
  output logic                    redirect_valid,
  output logic [XLEN-1:0]         redirect_pc,
  output logic                    exl,
  output logic [XLEN-1:0]         epc,
  output logic                    bd,
  output logic [CODE_W-1:0]       exc_code,
  output logic [XLEN-1:0]         badvaddr,
  output logic [CTX_HI-VPN_LO:0]  ctx_badvpn2,
  output logic [XCTX_HI-VPN_LO:0] xctx_badvpn2,
  output logic [1:0]              xctx_r,
  output logic [XCTX_HI-VPN_LO:0] hi_vpn2,
  output logic [1:0]              hi_region,
  output logic [1:0]              priv
);
  localparam int NSLOT = NREQ + 1;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [NSLOT-1:0] slot_valid, slot_grant;
  logic             exc_take, cp0_fault, exl_d;
  exc_cause_e       sel_cause;
  logic [XLEN-1:0]  sel_addr, target;
  cause_info_t      info;
  priv_e            priv_now, priv_next;

  exc_priv_decode u_priv_now  (.exl_in(exl),   .erl_in(erl), .ksu_in(ksu), .level(priv_now));
  exc_priv_decode u_priv_next (.exl_in(exl_d), .erl_in(erl), .ksu_in(ksu), .level(priv_next));

  assign cp0_fault  = cp0_access && (priv_now != PRIV_KERNEL) && !cu0;
  assign slot_valid = {cp0_fault, req_valid};

  exc_arbiter #(.N(NSLOT)) u_arb (
    .clk(clk), .rst(rst), .valid(slot_valid), .grant(slot_grant), .any(exc_take)
  );

  always_comb begin
    sel_cause = EX_COP_UNUSE;
    sel_addr  = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (slot_grant[i]) begin
        sel_cause = exc_cause_e'(req_cause[i*CAUSE_W +: CAUSE_W]);
        sel_addr  = req_addr[i*XLEN +: XLEN];
      end
    end
  end

  exc_code_map u_map (.cause(sel_cause), .info(info));

  exc_vector_gen #(.XLEN(XLEN)) u_vec (
    .bev(bev), .exl_now(exl), .refill(info.refill), .cp2_trap(info.cp2_trap),
    .base_off(base_off), .target(target)
  );

  assign exl_d = exc_take ? 1'b1 : (exl_clr ? 1'b0 : exl);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      exl            <= 1'b0;
      epc            <= '0;
      bd             <= 1'b0;
      exc_code       <= '0;
      badvaddr       <= '0;
      ctx_badvpn2    <= '0;
      xctx_badvpn2   <= '0;
      xctx_r         <= '0;
      hi_vpn2        <= '0;
      hi_region      <= '0;
      priv           <= PRIV_KERNEL;
    end else begin
      redirect_valid <= exc_take;
      exl            <= exl_d;
      priv           <= priv_next;
      if (exc_take) begin
        redirect_pc <= target;
        exc_code    <= info.code;
        if (!exl) begin
          epc <= in_delay ? (pc - INSN_BYTES) : pc;
          bd  <= in_delay;
        end
        if (info.tlb_class || info.addr_err) badvaddr <= sel_addr;
        if (info.tlb_class) begin
          ctx_badvpn2  <= sel_addr[CTX_HI:VPN_LO];
          xctx_badvpn2 <= sel_addr[XCTX_HI:VPN_LO];
          xctx_r       <= sel_addr[XLEN-1:XLEN-2];
          hi_vpn2      <= sel_addr[XCTX_HI:VPN_LO];
          hi_region    <= sel_addr[XLEN-1:XLEN-2];
        end
      end
    end
  end

  a_r1_exl_after_entry: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> exl);
  a_r2_nested_keeps_epc: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exl) |=> ($stable(epc) && $stable(bd)));
  a_r4_vector_low_byte: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (((redirect_pc + $past(base_off)) & XLEN'(8'hFF)) == XLEN'(8'h80)));
  a_r8_exl_is_kernel: assert property (@(posedge clk) disable iff (rst)
    exl |-> (priv == PRIV_KERNEL));
  a_r9_access_fault_code: assert property (@(posedge clk) disable iff (rst)
    (cp0_fault && req_valid == '0) |=> (exc_code == 5'h0B));
  a_r11_redirect_pulse: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> $past(exc_take));
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  localparam int NREQ = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NREQ-1:0]   req_valid = '0;
  logic [NREQ*5-1:0] req_cause = '0;
  logic [NREQ*64-1:0] req_addr = '0;
  logic [63:0] pc = '0, base_off = '0;
  logic in_delay = 0, bev = 0, erl = 0, cu0 = 0, cp0_access = 0, exl_clr = 0;
  logic [1:0] ksu = 2'b00;
  logic        redirect_valid, exl, bd;
  logic [63:0] redirect_pc, epc, badvaddr;
  logic [4:0]  exc_code;
  logic [18:0] ctx_badvpn2;
  logic [26:0] xctx_badvpn2, hi_vpn2;
  logic [1:0]  xctx_r, hi_region, priv;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cause(req_cause), .req_addr(req_addr),
    .pc(pc), .in_delay(in_delay), .base_off(base_off), .bev(bev), .erl(erl), .ksu(ksu),
    .cu0(cu0), .cp0_access(cp0_access), .exl_clr(exl_clr),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exl(exl), .epc(epc),
    .bd(bd), .exc_code(exc_code), .badvaddr(badvaddr), .ctx_badvpn2(ctx_badvpn2),
    .xctx_badvpn2(xctx_badvpn2), .xctx_r(xctx_r), .hi_vpn2(hi_vpn2),
    .hi_region(hi_region), .priv(priv)
  );

  typedef struct packed {
    logic [4:0]  cause;
    logic        bev;
    logic        nest;
    logic [63:0] off;
    logic [4:0]  code;
    logic [63:0] tgt;
  } vec_t;

  localparam vec_t VT [22] = '{
    '{5'd0,  1'b0, 1'b0, 64'h0,        5'h00, 64'hFFFFFFFF80000180},
    '{5'd1,  1'b0, 1'b0, 64'h0,        5'h01, 64'hFFFFFFFF80000180},
    '{5'd2,  1'b0, 1'b0, 64'h0,        5'h02, 64'hFFFFFFFF80000180},
    '{5'd3,  1'b1, 1'b0, 64'h0,        5'h03, 64'hFFFFFFFFBFC00380},
    '{5'd4,  1'b0, 1'b0, 64'h0,        5'h04, 64'hFFFFFFFF80000180},
    '{5'd5,  1'b0, 1'b1, 64'h0,        5'h05, 64'hFFFFFFFF80000180},
    '{5'd6,  1'b0, 1'b0, 64'h80000000, 5'h08, 64'hFFFFFFFF00000180},
    '{5'd7,  1'b0, 1'b0, 64'h0,        5'h09, 64'hFFFFFFFF80000180},
    '{5'd8,  1'b1, 1'b1, 64'h0,        5'h0A, 64'hFFFFFFFFBFC00380},
    '{5'd9,  1'b0, 1'b0, 64'h0,        5'h0B, 64'hFFFFFFFF80000180},
    '{5'd10, 1'b0, 1'b0, 64'h0,        5'h0C, 64'hFFFFFFFF80000180},
    '{5'd11, 1'b0, 1'b0, 64'h0,        5'h0D, 64'hFFFFFFFF80000180},
    '{5'd12, 1'b0, 1'b0, 64'h0,        5'h12, 64'hFFFFFFFF80000180},
    '{5'd13, 1'b0, 1'b0, 64'h0,        5'h12, 64'hFFFFFFFF80000280},
    '{5'd14, 1'b0, 1'b0, 64'h0,        5'h02, 64'hFFFFFFFF80000080},
    '{5'd15, 1'b1, 1'b0, 64'h0,        5'h03, 64'hFFFFFFFFBFC00280},
    '{5'd16, 1'b0, 1'b0, 64'h0,        5'h02, 64'hFFFFFFFF80000180},
    '{5'd17, 1'b0, 1'b0, 64'h0,        5'h03, 64'hFFFFFFFF80000180},
    '{5'd18, 1'b1, 1'b0, 64'h1000,     5'h18, 64'hFFFFFFFFBFBFF380},
    '{5'd13, 1'b0, 1'b1, 64'h0,        5'h12, 64'hFFFFFFFF80000180},
    '{5'd14, 1'b1, 1'b1, 64'h0,        5'h02, 64'hFFFFFFFFBFC00380},
    '{5'd13, 1'b1, 1'b0, 64'h10,       5'h12, 64'hFFFFFFFFBFC00470}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // drive at a falling edge, release at the next falling edge (outputs settled there)
  task automatic fire(input int slot, input logic [4:0] c, input logic [63:0] a);
    @(negedge clk);
    req_valid[slot] = 1'b1;
    req_cause[slot*5 +: 5] = c;
    req_addr[slot*64 +: 64] = a;
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic clear_exl();
    @(negedge clk); exl_clr = 1;
    @(negedge clk); exl_clr = 0;
  endtask

  function automatic bit is_tlb(input logic [4:0] c);
    return (c >= 5'd1 && c <= 5'd3) || (c >= 5'd14 && c <= 5'd17);
  endfunction

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 exl", exl, 0);
    chk("R12 redirect_valid", redirect_valid, 0);
    chk("R12 epc", epc, 0);
    chk("R12 bd", bd, 0);
    chk("R12 badvaddr", badvaddr, 0);
    chk("R12 exc_code", exc_code, 0);
    chk("R12 priv", priv, 0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 22; i++) begin
      logic [63:0] prev_bad, a, exp_epc, prev_ctx;
      logic exp_bd;
      bev = VT[i].bev;
      if (VT[i].nest) begin
        clear_exl();
        pc = 64'hAAAA_0000; in_delay = 0; base_off = 0;
        fire(0, 5'd0, 64'h0);
        exp_epc = 64'hAAAA_0000; exp_bd = 0;
      end else begin
        clear_exl();
        exp_bd  = i[0];
        exp_epc = 64'h4000 + 64'(i) * 8 - (i[0] ? 64'd4 : 64'd0);
      end
      prev_bad = badvaddr;
      prev_ctx = {45'd0, ctx_badvpn2};
      a = 64'hB000_00C3_5A5A_6000 + 64'(i) * 64'h0002_1000;
      pc = 64'h4000 + 64'(i) * 8; in_delay = i[0]; base_off = VT[i].off;
      fire(1, VT[i].cause, a);
      chk("R11 redirect_valid", redirect_valid, 1);
      chk("R4 redirect_pc", redirect_pc, VT[i].tgt);
      chk("R5 exc_code", exc_code, VT[i].code);
      chk("R1 exl", exl, 1);
      chk("R2/R3 epc", epc, exp_epc);
      chk("R2/R3 bd", bd, exp_bd);
      if (is_tlb(VT[i].cause)) begin
        chk("R6 ctx_badvpn2", ctx_badvpn2, a[31:13]);
        chk("R6 xctx_badvpn2", xctx_badvpn2, a[39:13]);
        chk("R6 hi_vpn2", hi_vpn2, a[39:13]);
        chk("R6 xctx_r", xctx_r, a[63:62]);
        chk("R6 hi_region", hi_region, a[63:62]);
      end else begin
        chk("R6 ctx unchanged", {45'd0, ctx_badvpn2}, prev_ctx);
      end
      if (is_tlb(VT[i].cause) || VT[i].cause == 5'd4 || VT[i].cause == 5'd5)
        chk("R7 badvaddr captured", badvaddr, a);
      else
        chk("R7 badvaddr unchanged", badvaddr, prev_bad);
      if (i == 0) begin
        @(negedge clk);
        chk("R11 pulse ends", redirect_valid, 0);
      end
    end
    bev = 0; base_off = 0; in_delay = 0;

    // R10 priority
    clear_exl();
    @(negedge clk);
    req_valid = 3'b101; req_cause = {5'd10, 5'd0, 5'd7};
    @(negedge clk); req_valid = '0;
    chk("R10 slot0 beats slot2", exc_code, 5'h09);
    clear_exl();
    @(negedge clk);
    req_valid = 3'b110; req_cause = {5'd2, 5'd3, 5'd0};
    req_addr = {64'h1111_0000_0000_0000, 64'h2222_0000_0000_0000, 64'h0};
    @(negedge clk); req_valid = '0;
    chk("R10 slot1 code", exc_code, 5'h03);
    chk("R10 slot1 addr", badvaddr, 64'h2222_0000_0000_0000);

    // R9 access check
    clear_exl();
    ksu = 2'b10; cu0 = 0;
    @(negedge clk); cp0_access = 1;
    @(negedge clk); cp0_access = 0;
    chk("R9 fault redirect", redirect_valid, 1);
    chk("R9 fault code", exc_code, 5'h0B);
    clear_exl();
    cu0 = 1;
    @(negedge clk); cp0_access = 1;
    @(negedge clk); cp0_access = 0;
    chk("R9 cu0 set ignored redirect", redirect_valid, 0);
    chk("R9 cu0 set ignored exl", exl, 0);
    cu0 = 0; ksu = 2'b00;
    @(negedge clk); cp0_access = 1;
    @(negedge clk); cp0_access = 0;
    chk("R9 kernel ignored", redirect_valid, 0);
    chk("R9 kernel ignored exl", exl, 0);
    // R10 access check loses to a requester
    ksu = 2'b01;
    @(negedge clk); cp0_access = 1; req_valid = 3'b100; req_cause = {5'd1, 10'd0};
    @(negedge clk); cp0_access = 0; req_valid = '0;
    chk("R10 requester beats access check", exc_code, 5'h01);

    // R8 privilege
    clear_exl();
    erl = 0;
    for (int k = 0; k < 4; k++) begin
      ksu = 2'(k);
      @(negedge clk); @(negedge clk);
      chk("R8 ksu decode", priv, (k == 0) ? 0 : (k == 1) ? 1 : 2);
    end
    erl = 1; @(negedge clk); @(negedge clk);
    chk("R8 erl kernel", priv, 0);
    erl = 0; fire(0, 5'd6, 64'h0); @(negedge clk);
    chk("R8 exl kernel", priv, 0);

    // R1 exl_clr alone and together with an exception
    clear_exl(); @(negedge clk);
    chk("R1 exl_clr clears", exl, 0);
    fire(0, 5'd6, 64'h0);
    @(negedge clk); exl_clr = 1; req_valid[0] = 1; req_cause[4:0] = 5'd6;
    @(negedge clk); exl_clr = 0; req_valid = '0;
    chk("R1 exception beats exl_clr", exl, 1);

    summary();
  end
endmodule